// File: doc/BRIEF.md
# Integer-N PLL Synthesizer Register Loader

This block programs an integer-N frequency synthesizer through a write-only three-wire serial port (clock, data, latch enable). A request carries the total feedback divide value `n`, a dual-modulus prescaler choice (8/9 or 16/17), three flag bits for the top of the divider word, and software-built payloads for the reference-divider word and the control word. The loader splits `n` into a main counter B and a swallow counter A for the chosen modulus. It tags each 24-bit word with its destination code and shifts the words out in the order the synthesizer needs.

The first programming after reset inserts a settling pause between the control word and the divider word. Later programmings skip the pause. After the divider word the loader reads the lock-detect input. If that read is low, it reads once more after a short wait. It then raises a one-cycle `done` with the lock result held on `locked`. A request whose counters cannot be realised is refused: `range_err` is set and nothing is shifted out.

Top module: `pll_prog_loader`

## Requirements
- R1: Bits 1:0 of every shifted word carry the destination code, replacing the payload's low two bits: 2'b01 for the reference word, 2'b00 for the control word, 2'b10 for the divider word.
- R2: One programming shifts exactly three 24-bit words in the order reference, control, divider. Each word goes most significant bit first and is sampled on the rising edge of `spi_sclk`. `spi_sdata` is stable while `spi_sclk` is high. `spi_le` is low while the bits move and is pulsed high for one bit period, with `spi_sclk` low, after the 24th bit.
- R3: With modulus P = 8 when `req_presc` = 0 and P = 16 when it is 1, B = floor(n/P) and A = n - P*B. The divider word is {req_nflags[2:0] at 23:21, B at 20:8, 0 at bit 7, A at 6:2, code at 1:0}.
- R4: The reference word carries req_r_payload[23:2]. The control word carries req_c_payload[21:2] at 21:2 and the prescaler field {1'b0, req_presc} at 23:22.
- R5: If B < A, or B exceeds 8191 (does not fit 13 bits), the request is refused. `range_err` is 1 at `done`, `locked` is 0, and no word is shifted.
- R6: On the first programming after reset, at least SETTLE_CYC clock cycles pass between the end of the control word's latch pulse and the first `spi_sclk` rise of the divider word. Later programmings insert no such pause. A refused request does not count as a programming.
- R7: One cycle after the divider word ends, `lock_det` is sampled. If it is low, it is sampled again RETRY_CYC cycles later. `locked` is 1 if either sample was high. It is valid at `done` and held until the next accepted request.
- R8: A request (`req_valid` high) is accepted only while `busy` is low; requests raised while busy are ignored. `busy` is high from the cycle after acceptance through the one-cycle `done` pulse and low the cycle after it.
- R9: After reset, `spi_sclk`, `spi_sdata`, `spi_le`, `busy`, `done`, `locked` and `range_err` are all 0.
- R10: Each high and low phase of `spi_sclk` lasts HALF_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_n | input | NW | Total feedback divide value |
| req_presc | input | 1 | Prescaler choice: 0 selects 8/9, 1 selects 16/17 |
| req_nflags | input | 3 | Bits 23:21 of the divider word |
| req_r_payload | input | 24 | Reference word payload |
| req_c_payload | input | 24 | Control word payload |
| lock_det | input | 1 | Lock-detect level from the synthesizer |
| spi_sclk | output | 1 | Serial clock |
| spi_sdata | output | 1 | Serial data |
| spi_le | output | 1 | Latch enable |
| busy | output | 1 | Programming in progress |
| done | output | 1 | One-cycle completion pulse |
| locked | output | 1 | Lock result of the last programming |
| range_err | output | 1 | Last request was refused |

## Verification
The bench builds the loader with HALF_DIV = 2, SETTLE_CYC = 200 and RETRY_CYC = 16. These values keep the first-write pause short enough to measure against its limit, and leave a wide window between the two lock samples, so a lock that rises only in that window can be placed with certainty. NW stays at 18, so random values of `n` reach both refusal conditions: B below A, and B beyond 13 bits with the 8/9 prescaler. A second reset in mid-run brings the first-write pause back into reach.

// File: rtl/pll_loader_pkg.sv
package pll_loader_pkg;
  localparam int WORD_W = 24;
  localparam int B_W    = 13;
  localparam int A_W    = 5;

  localparam logic [1:0] TAG_CTRL = 2'd0;
  localparam logic [1:0] TAG_REF  = 2'd1;
  localparam logic [1:0] TAG_DIV  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_REF, S_CTL, S_SETTLE, S_DIV,
    S_LK1, S_GAP, S_LK2, S_DONE
  } load_state_e;
endpackage

// File: rtl/pll_word_calc.sv
module pll_word_calc
  import pll_loader_pkg::*;
#(
  parameter int NW = 18
) (
  input  logic [NW-1:0]     n_val,
  input  logic              presc,
  input  logic [2:0]        nflags,
  input  logic [WORD_W-1:0] r_pay,
  input  logic [WORD_W-1:0] c_pay,
  output logic [WORD_W-1:0] r_word,
  output logic [WORD_W-1:0] c_word,
  output logic [WORD_W-1:0] n_word,
  output logic              bad
);
  localparam logic [NW-1:0] B_LIMIT = NW'((1 << B_W) - 1);

  logic [NW-1:0] b_full;
  logic [3:0]    a_val;

  always_comb begin
    b_full = presc ? (n_val >> 4) : (n_val >> 3);
    a_val  = presc ? n_val[3:0] : {1'b0, n_val[2:0]};
    bad    = (b_full < NW'(a_val)) || (b_full > B_LIMIT);
    r_word = {r_pay[WORD_W-1:2], TAG_REF};
    c_word = {1'b0, presc, c_pay[21:2], TAG_CTRL};
    n_word = {nflags, b_full[B_W-1:0], 1'b0, {(A_W-4){1'b0}}, a_val, TAG_DIV};
  end
endmodule

// File: rtl/pll_ser_shift.sv
module pll_ser_shift
  import pll_loader_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              sdata,
  output logic              sle,
  output logic              active,
  output logic              word_done
);
  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PH_W    = $clog2(2 * WORD_W + 2);
  localparam int LE_PH   = 2 * WORD_W;
  localparam int LAST_PH = 2 * WORD_W + 1;

  logic              act_q, act_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              tick;

  assign tick = act_q && (div_q == DIV_W'(HALF_DIV - 1));

  always_comb begin
    act_d     = act_q;
    ph_d      = ph_q;
    div_d     = div_q;
    sh_d      = sh_q;
    word_done = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        ph_d  = '0;
        div_d = '0;
        sh_d  = word;
      end
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (ph_q == PH_W'(LAST_PH)) begin
          act_d     = 1'b0;
          word_done = 1'b1;
        end else begin
          ph_d = ph_q + 1'b1;
          if (ph_q[0] && (ph_q < PH_W'(LE_PH - 1)))
            sh_d = {sh_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      div_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      div_q <= div_d;
      sh_q  <= sh_d;
    end
  end

  assign active = act_q;
  assign sclk   = act_q && (ph_q < PH_W'(LE_PH)) && ph_q[0];
  assign sdata  = act_q && (ph_q < PH_W'(LE_PH)) && sh_q[WORD_W-1];
  assign sle    = act_q && (ph_q >= PH_W'(LE_PH));

  // R2: no clock edge while the latch pulse is high
  p_le_no_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sle |-> !sclk);
  // R2: data held for the whole high phase of the serial clock
  p_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));
  // R10: the serial clock never toggles between divider ticks
  p_sclk_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && (div_q != '0)) |-> $stable(sclk));
endmodule

// File: rtl/pll_load_seq.sv
module pll_load_seq
  import pll_loader_pkg::*;
#(
  parameter int NW         = 18,
  parameter int SETTLE_CYC = 2000000,
  parameter int RETRY_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [NW-1:0]     req_n,
  input  logic              req_presc,
  input  logic [2:0]        req_nflags,
  input  logic [WORD_W-1:0] req_r_payload,
  input  logic [WORD_W-1:0] req_c_payload,
  input  logic              lock_det,
  input  logic              calc_bad,
  input  logic [WORD_W-1:0] r_word,
  input  logic [WORD_W-1:0] c_word,
  input  logic [WORD_W-1:0] n_word,
  input  logic              sh_active,
  input  logic              sh_done,
  output logic [NW-1:0]     lat_n,
  output logic              lat_presc,
  output logic [2:0]        lat_nflags,
  output logic [WORD_W-1:0] lat_rp,
  output logic [WORD_W-1:0] lat_cp,
  output logic              sh_start,
  output logic [WORD_W-1:0] sh_word,
  output logic              busy,
  output logic              done,
  output logic              locked,
  output logic              range_err
);
  localparam int CNT_MAX = (SETTLE_CYC > RETRY_CYC) ? SETTLE_CYC : RETRY_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  load_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic             lock_q, lock_d;
  logic             err_q, err_d;
  logic             accept;

  assign accept = (state_q == S_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    lock_d  = lock_q;
    err_d   = err_q;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        state_d = S_CHK;
        lock_d  = 1'b0;
        err_d   = 1'b0;
      end
      S_CHK: if (calc_bad) begin
        state_d = S_DONE;
        err_d   = 1'b1;
      end else begin
        state_d = S_REF;
      end
      S_REF: if (sh_done) state_d = S_CTL;
      S_CTL: if (sh_done) begin
        state_d = first_q ? S_SETTLE : S_DIV;
        cnt_d   = '0;
      end
      S_SETTLE: if (cnt_q == CNT_W'(SETTLE_CYC - 1)) state_d = S_DIV;
                else cnt_d = cnt_q + 1'b1;
      S_DIV: if (sh_done) begin
        state_d = S_LK1;
        first_d = 1'b0;
      end
      S_LK1: if (lock_det) begin
        lock_d  = 1'b1;
        state_d = S_DONE;
      end else begin
        state_d = S_GAP;
        cnt_d   = '0;
      end
      S_GAP: if (cnt_q == CNT_W'(RETRY_CYC - 1)) state_d = S_LK2;
             else cnt_d = cnt_q + 1'b1;
      S_LK2: begin
        lock_d  = lock_det;
        state_d = S_DONE;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b1;
      lock_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      lock_q  <= lock_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_n      <= '0;
      lat_presc  <= 1'b0;
      lat_nflags <= '0;
      lat_rp     <= '0;
      lat_cp     <= '0;
    end else if (accept) begin
      lat_n      <= req_n;
      lat_presc  <= req_presc;
      lat_nflags <= req_nflags;
      lat_rp     <= req_r_payload;
      lat_cp     <= req_c_payload;
    end
  end

  always_comb begin
    sh_start = !sh_active &&
               ((state_q == S_REF) || (state_q == S_CTL) || (state_q == S_DIV));
    unique case (state_q)
      S_REF:   sh_word = r_word;
      S_CTL:   sh_word = c_word;
      default: sh_word = n_word;
    endcase
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign locked    = lock_q;
  assign range_err = err_q;

  // R8: busy drops the cycle after the done pulse
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R8: a request raised while busy never restarts the check
  p_no_reaccept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (state_q != S_CHK));
  // R6: the settling pause happens only before any successful programming
  p_settle_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SETTLE) |-> first_q);
  // R5: a refused request leaves the serial port quiet
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> !sh_active);
  // R7: the lock result does not move while idle
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(locked));
  // R1: the shifter is never launched with an unused destination code
  p_tag_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> (sh_word[1:0] != 2'b11));
endmodule

// File: rtl/pll_prog_loader.sv
module pll_prog_loader
  import pll_loader_pkg::*;
#(
  parameter int NW         = 18,
  parameter int HALF_DIV   = 4,
  parameter int SETTLE_CYC = 2000000,
  parameter int RETRY_CYC  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [NW-1:0] req_n,
  input  logic          req_presc,
  input  logic [2:0]    req_nflags,
  input  logic [23:0]   req_r_payload,
  input  logic [23:0]   req_c_payload,
  input  logic          lock_det,
  output logic          spi_sclk,
  output logic          spi_sdata,
  output logic          spi_le,
  output logic          busy,
  output logic          done,
  output logic          locked,
  output logic          range_err
);
  logic              rst_meta, rst_sync;
  logic [NW-1:0]     lat_n;
  logic              lat_presc;
  logic [2:0]        lat_nflags;
  logic [WORD_W-1:0] lat_rp, lat_cp;
  logic [WORD_W-1:0] r_word, c_word, n_word, sh_word;
  logic              calc_bad, sh_start, sh_active, sh_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pll_load_seq #(
    .NW(NW), .SETTLE_CYC(SETTLE_CYC), .RETRY_CYC(RETRY_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync),
    .req_valid(req_valid), .req_n(req_n), .req_presc(req_presc),
    .req_nflags(req_nflags), .req_r_payload(req_r_payload),
    .req_c_payload(req_c_payload), .lock_det(lock_det),
    .calc_bad(calc_bad), .r_word(r_word), .c_word(c_word), .n_word(n_word),
    .sh_active(sh_active), .sh_done(sh_done),
    .lat_n(lat_n), .lat_presc(lat_presc), .lat_nflags(lat_nflags),
    .lat_rp(lat_rp), .lat_cp(lat_cp),
    .sh_start(sh_start), .sh_word(sh_word),
    .busy(busy), .done(done), .locked(locked), .range_err(range_err)
  );

  pll_word_calc #(.NW(NW)) u_calc (
    .n_val(lat_n), .presc(lat_presc), .nflags(lat_nflags),
    .r_pay(lat_rp), .c_pay(lat_cp),
    .r_word(r_word), .c_word(c_word), .n_word(n_word), .bad(calc_bad)
  );

  pll_ser_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_sync), .start(sh_start), .word(sh_word),
    .sclk(spi_sclk), .sdata(spi_sdata), .sle(spi_le),
    .active(sh_active), .word_done(sh_done)
  );
endmodule

// File: tb/pll_prog_loader_bench.sv
`timescale 1ns/1ps
module pll_prog_loader_bench;
  localparam int NW = 18, HALF_DIV = 2, SETTLE_CYC = 200, RETRY_CYC = 16;
  localparam real TCK = 5.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_presc = 1'b0, lock_det = 1'b0;
  logic [NW-1:0] req_n = '0;
  logic [2:0]  req_nflags = '0;
  logic [23:0] req_r_payload = '0, req_c_payload = '0;
  logic spi_sclk, spi_sdata, spi_le, busy, done, locked, range_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pll_prog_loader #(.NW(NW), .HALF_DIV(HALF_DIV), .SETTLE_CYC(SETTLE_CYC),
                    .RETRY_CYC(RETRY_CYC)) u_pll_prog_loader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_n(req_n),
    .req_presc(req_presc), .req_nflags(req_nflags),
    .req_r_payload(req_r_payload), .req_c_payload(req_c_payload),
    .lock_det(lock_det), .spi_sclk(spi_sclk), .spi_sdata(spi_sdata),
    .spi_le(spi_le), .busy(busy), .done(done), .locked(locked),
    .range_err(range_err));

  // serial monitor
  logic [23:0] sh_cap = '0;
  int          bits = 0;
  logic [7:0]  wcnt = '0;
  logic [23:0] cap   [256];
  int          nbits [256];
  realtime     le_fall_t [256];
  realtime     first_clk_t [256];
  realtime     hi_start = 0.0;
  int          width_errs = 0;

  always @(posedge spi_sclk) begin
    if (bits == 0) first_clk_t[wcnt] = $realtime;
    sh_cap = {sh_cap[22:0], spi_sdata};
    bits++;
    hi_start = $realtime;
  end
  always @(negedge spi_sclk) begin
    if (($realtime - hi_start) < HALF_DIV*TCK - 0.1 ||
        ($realtime - hi_start) > HALF_DIV*TCK + 0.1) width_errs++;
  end
  always @(posedge spi_le) begin
    cap[wcnt] = sh_cap;
    nbits[wcnt] = bits;
    bits = 0;
    wcnt = wcnt + 8'd1;
  end
  always @(negedge spi_le) le_fall_t[wcnt - 8'd1] = $realtime;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_bad(input logic [NW-1:0] n, input logic p);
    int b, a;
    b = p ? int'(n) / 16 : int'(n) / 8;
    a = p ? int'(n) % 16 : int'(n) % 8;
    return (b < a) || (b > 8191);
  endfunction

  function automatic logic [23:0] exp_div(input logic [NW-1:0] n, input logic p,
                                          input logic [2:0] f);
    int b, a;
    b = p ? int'(n) / 16 : int'(n) / 8;
    a = p ? int'(n) % 16 : int'(n) % 8;
    return {f, 13'(b), 1'b0, 5'(a), 2'b10};
  endfunction

  bit first_exp = 1;

  // lmode: 0 lock high, 1 lock low, 2 lock rises between the two samples
  task automatic run_req(input logic [NW-1:0] n, input logic p,
                         input logic [2:0] f, input logic [23:0] rp,
                         input logic [23:0] cp, input int lmode, input bit ign);
    logic [7:0] wb;
    bit bad_e, lk_e;
    int k = 0, after = -1;
    realtime gap;
    @(negedge clk);
    wb = wcnt;
    lock_det = (lmode == 0);
    req_n = n; req_presc = p; req_nflags = f;
    req_r_payload = rp; req_c_payload = cp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 1);
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
      if (ign && k == 5) begin
        req_valid = 1'b1; req_n = ~n; req_presc = ~p; req_r_payload = ~rp;
      end else req_valid = 1'b0;
      if (lmode == 2 && wcnt == wb + 8'd3 && !spi_le) begin
        after++;
        if (after == 8) lock_det = 1'b1;
      end
    end
    bad_e = exp_bad(n, p);
    lk_e  = !bad_e && (lmode != 1);
    chk(done == 1'b1, "R8 done seen", 32'(done), 1);
    chk(range_err == bad_e, "R5 range_err", 32'(range_err), 32'(bad_e));
    chk(locked == lk_e, "R7 locked", 32'(locked), 32'(lk_e));
    if (bad_e) begin
      chk(wcnt == wb, "R5 no words shifted", 32'(wcnt - wb), 0);
    end else begin
      chk(wcnt == wb + 8'd3, "R2 word count", 32'(wcnt - wb), 3);
      chk(cap[wb] == {rp[23:2], 2'b01}, "R1 R4 reference word",
          32'(cap[wb]), 32'({rp[23:2], 2'b01}));
      chk(cap[wb+8'd1] == {1'b0, p, cp[21:2], 2'b00}, "R1 R4 control word",
          32'(cap[wb+8'd1]), 32'({1'b0, p, cp[21:2], 2'b00}));
      chk(cap[wb+8'd2] == exp_div(n, p, f), "R1 R3 divider word",
          32'(cap[wb+8'd2]), 32'(exp_div(n, p, f)));
      for (int i = 0; i < 3; i++)
        chk(nbits[wb + 8'(i)] == 24, "R2 bits per word",
            32'(nbits[wb + 8'(i)]), 24);
      gap = first_clk_t[wb+8'd2] - le_fall_t[wb+8'd1];
      if (first_exp)
        chk(gap >= SETTLE_CYC*TCK, "R6 first pause", 32'(int'(gap/TCK)),
            32'(SETTLE_CYC));
      else
        chk(gap < SETTLE_CYC*TCK, "R6 no later pause", 32'(int'(gap/TCK)),
            32'(SETTLE_CYC));
      first_exp = 0;
    end
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8 busy drops after done",
        32'({busy, done}), 0);
    lock_det = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({spi_sclk, spi_sdata, spi_le, busy, done, locked, range_err} == '0,
        "R9 reset state", 32'({spi_sclk, spi_sdata, spi_le, busy, done, locked,
        range_err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    first_exp = 1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // refused first request must not consume the first-write pause (R5, R6)
    run_req(18'd239, 1'b1, 3'b000, 24'h123456, 24'h654321, 0, 0);
    run_req(18'd0, 1'b1, 3'b101, 24'hFFFFFF, 24'hFFFFFF, 0, 0);
    run_req(18'd255, 1'b1, 3'b010, 24'hA5A5A5, 24'h5A5A5A, 0, 0);
    run_req(18'd65535, 1'b0, 3'b111, 24'h0F0F0F, 24'hF0F0F0, 0, 0);
    run_req(18'd65536, 1'b0, 3'b001, 24'h111111, 24'h222222, 0, 0);
    run_req(18'd131071, 1'b1, 3'b100, 24'h333333, 24'h444444, 0, 0);
    run_req(18'd131072, 1'b1, 3'b100, 24'h333333, 24'h444444, 0, 0);
    // lock variants (R7) and ignored request while busy (R8)
    run_req(18'd2401, 1'b1, 3'b000, 24'h00FF00, 24'h112233, 1, 0);
    run_req(18'd2401, 1'b1, 3'b000, 24'h00FF00, 24'h112233, 2, 0);
    run_req(18'd900, 1'b0, 3'b011, 24'hC0FFEE, 24'hBEEF01, 0, 1);
    // second reset restores the first-write pause (R6)
    do_reset();
    run_req(18'd1800, 1'b1, 3'b000, 24'h135790, 24'h246801, 0, 0);
    run_req(18'd1801, 1'b1, 3'b000, 24'h135790, 24'h246801, 0, 0);
    for (int i = 0; i < 30; i++) begin
      logic [NW-1:0] rn;
      rn = NW'($urandom);
      if (i % 3 == 0) rn = NW'($urandom % 600);
      run_req(rn, 1'($urandom), 3'($urandom), 24'($urandom), 24'($urandom),
              ($urandom % 4 == 0) ? 1 : 0, ($urandom % 5 == 0));
    end
    chk(width_errs == 0, "R10 serial clock high width", 32'(width_errs), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(150000 * TCK);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule